// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers eighteen interrupt request lines and forwards at most one of them at a time to a processor core. It also reports the winning source's index and its priority level. The lines are split into six groups of three consecutive sources. Each group is given one of four priority levels through a two-bit field, and every source in a group inherits that level. A rising edge on a line latches a pending flag. A flag is offered to the core only while its per-source enable and the global enable are both set.

The core takes a request with a one-cycle acknowledge pulse. That pulse clears the flag of the presented source and records the source's level as the current service level. A pending request interrupts an ongoing service only when its level is strictly above the level being serviced. Active levels are held on a four-entry stack, and a one-cycle return pulse pops the top entry. Separately, a wake output tells a power controller that a sleeping device should resume. It is raised when any pending source in a selectable subset needs attention.

Top module: `gpic_top`

## Requirements
- R1: After reset no request is presented, no flag is pending, the active-level stack is empty and `wake_o` is low.
- R2: A low-to-high transition of `irq_in[s]` sets the pending flag of source s. A line held high does not set the flag again after the flag is cleared.
- R3: A pending source is presented only while `src_en[s]` and `glob_en` are both 1. Clearing either enable hides the request but keeps the flag, so the request reappears once the enable returns.
- R4: Source s belongs to group g = s/3 and takes its level from `grp_lvl[2g+1:2g]`. `irq_lvl_o` shows that level, and 3 is the highest level.
- R5: Among the eligible pending sources, the one with the highest level is presented. When levels are equal, the lowest source index wins, and `irq_vec_o` equals that index.
- R6: An `ack_i` pulse taken while `irq_req_o` is 1 clears the flag of the source on `irq_vec_o` and pushes its level onto the stack. An `ack_i` pulse taken while `irq_req_o` is 0 has no effect.
- R7: While the stack holds a level, `irq_req_o` is 1 only for a candidate whose level is strictly greater than the top entry. A candidate at an equal or lower level waits.
- R8: A `reti_i` pulse pops the top stack entry, and this can let a waiting lower-level request through. A pulse on an empty stack is ignored.
- R9: Four nested services, one at each level, are tracked. A lower-level request stays held until all four have returned.
- R10: `wake_o` is 1 exactly when `sleep_i` is 1 and some pending source has its `wake_sel` bit set. The output does not depend on `src_en` or `glob_en`.
- R11: If a new rising edge on a source arrives in the same cycle as the acknowledge of that same source, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 18 | Interrupt request lines, edge sensitive |
| src_en | input | 18 | Per-source enables |
| glob_en | input | 1 | Global enable |
| grp_lvl | input | 12 | Two-bit level per group, group g at bits [2g+1:2g] |
| wake_sel | input | 18 | Sources allowed to raise the wake output |
| sleep_i | input | 1 | Device is in a sleep mode |
| ack_i | input | 1 | Acknowledge pulse from the core |
| reti_i | input | 1 | Return-from-interrupt pulse from the core |
| irq_req_o | output | 1 | Request to the core |
| irq_vec_o | output | 5 | Index of the presented source |
| irq_lvl_o | output | 2 | Level of the presented source |
| wake_o | output | 1 | Wake indication to the power controller |

## Verification
The bench targets ties between equal-level sources; a resolver that scanned in the wrong direction would present index 4 instead of 1. It builds a four-deep nest and then unwinds it one level at a time. A design that dropped a stack entry, or that allowed preemption at equal level, would present the waiting level-0 source too early. It also lands a fresh edge in the same cycle as an acknowledge, where a clear-wins flag would lose the new event. Finally, it acknowledges while requests are masked, where a design that ignored the request qualifier would clear a flag without serving it.

// File: rtl/gpic_pkg.sv
package gpic_pkg;

  // Default geometry of the controller
  localparam int unsigned GPIC_NUM_SRC     = 18;
  localparam int unsigned GPIC_SRC_PER_GRP = 3;
  localparam int unsigned GPIC_LVL_W       = 2;

endpackage

// File: rtl/gpic_flags.sv
// Edge capture and pending-flag storage, one flag per source.
module gpic_flags #(
  parameter int unsigned NUM_SRC = 18,
  parameter int unsigned VEC_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_in,
  input  logic               clr_vld,
  input  logic [VEC_W-1:0]   clr_idx,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_d;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] clr_hot;

  // next state: a new edge wins over a simultaneous clear
  always_comb begin
    rise = req_in & ~prev_q;
    for (int i = 0; i < NUM_SRC; i++) begin
      clr_hot[i] = clr_vld && (clr_idx == VEC_W'(i));
    end
    pend_d = rise | (pend_q & ~clr_hot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= req_in;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/gpic_resolve.sv
// Level lookup per source and selection of the winning candidate.
module gpic_resolve #(
  parameter int unsigned NUM_SRC     = 18,
  parameter int unsigned SRC_PER_GRP = 3,
  parameter int unsigned LVL_W       = 2,
  parameter int unsigned VEC_W       = 5,
  localparam int unsigned NUM_GRP    = NUM_SRC / SRC_PER_GRP
) (
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC-1:0]       src_en,
  input  logic                     glob_en,
  input  logic [NUM_GRP*LVL_W-1:0] grp_lvl,
  output logic                     cand_vld,
  output logic [VEC_W-1:0]         cand_idx,
  output logic [LVL_W-1:0]         cand_lvl
);

  logic [LVL_W-1:0]   src_lvl [NUM_SRC];
  logic [NUM_SRC-1:0] elig;

  // every member of a group inherits the group's level
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar k = 0; k < SRC_PER_GRP; k++) begin : g_mbr
      assign src_lvl[g*SRC_PER_GRP + k] = grp_lvl[g*LVL_W +: LVL_W];
    end
  end

  assign elig = pend & src_en & {NUM_SRC{glob_en}};

  // scan downwards; ">=" lets a lower index take over a tie
  always_comb begin
    cand_vld = 1'b0;
    cand_idx = '0;
    cand_lvl = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (!cand_vld || src_lvl[i] >= cand_lvl)) begin
        cand_vld = 1'b1;
        cand_lvl = src_lvl[i];
        cand_idx = VEC_W'(i);
      end
    end
  end

endmodule

// File: rtl/gpic_stack.sv
// Stack of levels currently in service.
module gpic_stack #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LVL_W = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic             top_vld,
  output logic [LVL_W-1:0] top_lvl,
  output logic [CNT_W-1:0] depth_o
);

  logic [LVL_W-1:0] stk_q [DEPTH];
  logic [LVL_W-1:0] stk_d [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] base;
  logic             pop_ok;
  logic             push_ok;
  logic             upd_en;

  // pop is applied first, then push, when both arrive together
  always_comb begin
    pop_ok  = pop && (cnt_q != '0);
    base    = cnt_q - CNT_W'(pop_ok);
    push_ok = push && (base < CNT_W'(DEPTH));
    cnt_d   = base + CNT_W'(push_ok);
    upd_en  = pop_ok || push_ok;
    stk_d   = stk_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (push_ok && (base == CNT_W'(i))) begin
        stk_d[i] = push_lvl;
      end
    end
  end

  always_comb begin
    top_vld = (cnt_q != '0);
    top_lvl = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) begin
        top_lvl = stk_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stk_q[i] <= '0;
      end
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      stk_q <= stk_d;
    end
  end

  assign depth_o = cnt_q;

endmodule

// File: rtl/gpic_top.sv
module gpic_top #(
  parameter int unsigned NUM_SRC     = gpic_pkg::GPIC_NUM_SRC,
  parameter int unsigned SRC_PER_GRP = gpic_pkg::GPIC_SRC_PER_GRP,
  parameter int unsigned LVL_W       = gpic_pkg::GPIC_LVL_W,
  localparam int unsigned NUM_GRP    = NUM_SRC / SRC_PER_GRP,
  localparam int unsigned STK_DEPTH  = 1 << LVL_W,
  localparam int unsigned VEC_W      = $clog2(NUM_SRC),
  localparam int unsigned CNT_W      = $clog2(STK_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       irq_in,
  input  logic [NUM_SRC-1:0]       src_en,
  input  logic                     glob_en,
  input  logic [NUM_GRP*LVL_W-1:0] grp_lvl,
  input  logic [NUM_SRC-1:0]       wake_sel,
  input  logic                     sleep_i,
  input  logic                     ack_i,
  input  logic                     reti_i,
  output logic                     irq_req_o,
  output logic [VEC_W-1:0]         irq_vec_o,
  output logic [LVL_W-1:0]         irq_lvl_o,
  output logic                     wake_o
);

  logic [1:0]         rst_pipe;
  logic               rst_core_n;
  logic [NUM_SRC-1:0] pend_q;
  logic               cand_vld;
  logic [VEC_W-1:0]   cand_idx;
  logic [LVL_W-1:0]   cand_lvl;
  logic               top_vld;
  logic [LVL_W-1:0]   top_lvl;
  logic [CNT_W-1:0]   stk_cnt;
  logic               ack_ok;

  // asynchronous assertion, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  gpic_flags #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .req_in  (irq_in),
    .clr_vld (ack_ok),
    .clr_idx (cand_idx),
    .pend_o  (pend_q)
  );

  gpic_resolve #(
    .NUM_SRC     (NUM_SRC),
    .SRC_PER_GRP (SRC_PER_GRP),
    .LVL_W       (LVL_W),
    .VEC_W       (VEC_W)
  ) u_resolve (
    .pend     (pend_q),
    .src_en   (src_en),
    .glob_en  (glob_en),
    .grp_lvl  (grp_lvl),
    .cand_vld (cand_vld),
    .cand_idx (cand_idx),
    .cand_lvl (cand_lvl)
  );

  gpic_stack #(
    .DEPTH (STK_DEPTH),
    .LVL_W (LVL_W),
    .CNT_W (CNT_W)
  ) u_stack (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .push     (ack_ok),
    .push_lvl (cand_lvl),
    .pop      (reti_i),
    .top_vld  (top_vld),
    .top_lvl  (top_lvl),
    .depth_o  (stk_cnt)
  );

  // preemption only by a strictly higher level
  assign irq_req_o = cand_vld && (!top_vld || (cand_lvl > top_lvl));
  assign irq_vec_o = cand_idx;
  assign irq_lvl_o = cand_lvl;
  assign ack_ok    = ack_i && irq_req_o;

  assign wake_o = sleep_i && |(pend_q & wake_sel);

endmodule

// File: rtl/gpic_chk.sv
module gpic_chk #(
  parameter int unsigned NUM_SRC = 18,
  parameter int unsigned VEC_W   = 5,
  parameter int unsigned LVL_W   = 2,
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned DEPTH   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_in,
  input logic [NUM_SRC-1:0] src_en,
  input logic               glob_en,
  input logic               sleep_i,
  input logic               ack_i,
  input logic               reti_i,
  input logic               irq_req_o,
  input logic [VEC_W-1:0]   irq_vec_o,
  input logic [LVL_W-1:0]   irq_lvl_o,
  input logic               wake_o,
  input logic [NUM_SRC-1:0] pend,
  input logic               top_vld,
  input logic [LVL_W-1:0]   top_lvl,
  input logic [CNT_W-1:0]   depth
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_rise
    // R2
    rise_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_in[i] && !$past(irq_in[i])) |=> pend[i]);
  end

  // R3
  global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !irq_req_o);

  // R5
  presented_is_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (pend[irq_vec_o] && src_en[irq_vec_o]));

  // R6
  ack_pushes_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_req_o && !reti_i) |=> (top_vld && top_lvl == $past(irq_lvl_o)));

  // R8
  reti_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && depth != '0 && !(ack_i && irq_req_o)) |=> (depth == $past(depth) - 1'b1));

  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));

  // R10
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |-> !wake_o);

endmodule

bind gpic_top gpic_chk #(
  .NUM_SRC (NUM_SRC),
  .VEC_W   (VEC_W),
  .LVL_W   (LVL_W),
  .CNT_W   (CNT_W),
  .DEPTH   (STK_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .irq_in    (irq_in),
  .src_en    (src_en),
  .glob_en   (glob_en),
  .sleep_i   (sleep_i),
  .ack_i     (ack_i),
  .reti_i    (reti_i),
  .irq_req_o (irq_req_o),
  .irq_vec_o (irq_vec_o),
  .irq_lvl_o (irq_lvl_o),
  .wake_o    (wake_o),
  .pend      (pend_q),
  .top_vld   (top_vld),
  .top_lvl   (top_lvl),
  .depth     (stk_cnt)
);

// File: tb/gpic_top_tb.sv
module gpic_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] irq_in, src_en, wake_sel;
  logic        glob_en, sleep_i, ack_i, reti_i;
  logic [11:0] grp_lvl;
  logic        irq_req_o, wake_o;
  logic [4:0]  irq_vec_o;
  logic [1:0]  irq_lvl_o;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;
  bit done   = 0;

  // behavioural reference state
  bit m_pend [NS];
  bit m_prev [NS];
  int m_stk [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpic_top u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .src_en(src_en),
    .glob_en(glob_en), .grp_lvl(grp_lvl), .wake_sel(wake_sel),
    .sleep_i(sleep_i), .ack_i(ack_i), .reti_i(reti_i),
    .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o),
    .irq_lvl_o(irq_lvl_o), .wake_o(wake_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void m_pick(output bit req, output int vec, output int lvl);
    bit found = 0;
    vec = 0; lvl = 0;
    for (int l = 3; l >= 0 && !found; l--) begin
      for (int s = 0; s < NS && !found; s++) begin
        if (m_pend[s] && src_en[s] && glob_en && int'(grp_lvl[2*(s/3) +: 2]) == l) begin
          found = 1; vec = s; lvl = l;
        end
      end
    end
    req = found && (m_stk.size() == 0 || lvl > m_stk[m_stk.size()-1]);
  endfunction

  function automatic bit m_wake();
    bit w = 0;
    for (int s = 0; s < NS; s++) if (m_pend[s] && wake_sel[s]) w = 1;
    return sleep_i && w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin m_pend[s] = 0; m_prev[s] = 0; end
      m_stk.delete();
    end else begin
      bit r; int v; int l; bit ack_ok;
      m_pick(r, v, l);
      ack_ok = ack_i && r;
      for (int s = 0; s < NS; s++) begin
        m_pend[s] = (irq_in[s] && !m_prev[s]) || (m_pend[s] && !(ack_ok && s == v));
        m_prev[s] = irq_in[s];
      end
      if (reti_i && m_stk.size() > 0) void'(m_stk.pop_back());
      if (ack_ok) m_stk.push_back(l);
    end
  end

  // every-cycle comparison with the reference
  always @(negedge clk) begin
    if (cmp_on) begin
      bit r; int v; int l;
      m_pick(r, v, l);
      chk("MODEL req (R5/R7)", int'(irq_req_o), int'(r));
      if (r) begin
        chk("MODEL vec (R5)", int'(irq_vec_o), v);
        chk("MODEL lvl (R4)", int'(irq_lvl_o), l);
      end
      chk("MODEL wake (R10)", int'(wake_o), int'(m_wake()));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic settle();
    @(negedge clk);
  endtask
  task automatic pulse_ack();
    tick(); ack_i = 1; tick(); ack_i = 0;
  endtask
  task automatic pulse_reti();
    tick(); reti_i = 1; tick(); reti_i = 0;
  endtask
  task automatic rearm(input int s);
    tick(); irq_in[s] = 0; tick(); irq_in[s] = 1; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_n = 0; irq_in = '0; src_en = '1; wake_sel = '0; glob_en = 1;
    sleep_i = 0; ack_i = 0; reti_i = 0; grp_lvl = '0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    cmp_on = 1;
    settle();
    chk("R1 req after reset", int'(irq_req_o), 0);
    chk("R1 wake after reset", int'(wake_o), 0);

    // tie at level 0: lower index wins
    tick(); irq_in[4] = 1; irq_in[1] = 1; tick(); settle();
    chk("R2 edge latched req", int'(irq_req_o), 1);
    chk("R5 tie lowest index", int'(irq_vec_o), 1);

    // group 2 at level 2
    tick(); grp_lvl[5:4] = 2'd2; irq_in[7] = 1; tick(); settle();
    chk("R5 highest level vec", int'(irq_vec_o), 7);
    chk("R4 group level", int'(irq_lvl_o), 2);

    pulse_ack(); settle();
    chk("R7 lower waits", int'(irq_req_o), 0);

    // group 3 at level 3 preempts
    tick(); grp_lvl[7:6] = 2'd3; irq_in[10] = 1; tick(); settle();
    chk("R7 higher preempts req", int'(irq_req_o), 1);
    chk("R7 higher preempts vec", int'(irq_vec_o), 10);
    pulse_ack(); settle();
    chk("R6 ack clears", int'(irq_req_o), 0);

    tick(); irq_in[11] = 1; tick(); settle();
    chk("R7 equal level waits", int'(irq_req_o), 0);

    pulse_reti(); settle();
    chk("R8 pop exposes req", int'(irq_req_o), 1);
    chk("R8 pop exposes vec", int'(irq_vec_o), 11);
    pulse_ack();
    tick(); reti_i = 1; tick(); tick(); reti_i = 0; settle();
    chk("R8 empty stack vec", int'(irq_vec_o), 1);

    // four-deep nest
    pulse_ack(); settle();
    chk("R7 level0 over level0", int'(irq_req_o), 0);
    tick(); grp_lvl[3:2] = 2'd1; tick(); settle();
    chk("R4 level1 vec", int'(irq_vec_o), 4);
    chk("R7 level1 preempts", int'(irq_req_o), 1);
    pulse_ack();
    rearm(7); settle();
    chk("R9 level2 vec", int'(irq_vec_o), 7);
    pulse_ack();
    rearm(10); settle();
    chk("R9 level3 vec", int'(irq_vec_o), 10);
    pulse_ack();
    tick(); irq_in[2] = 1; tick(); settle();
    chk("R9 depth4 holds", int'(irq_req_o), 0);
    tick(); reti_i = 1; tick(); tick(); tick(); reti_i = 0; settle();
    chk("R9 three pops still held", int'(irq_req_o), 0);
    pulse_reti(); settle();
    chk("R9 fourth pop releases", int'(irq_req_o), 1);
    chk("R9 released vec", int'(irq_vec_o), 2);

    // enables
    tick(); src_en[2] = 0; tick(); settle();
    chk("R3 source masked", int'(irq_req_o), 0);
    tick(); src_en[2] = 1; tick(); settle();
    chk("R3 flag kept vec", int'(irq_vec_o), 2);
    tick(); glob_en = 0; tick(); settle();
    chk("R3 global mask", int'(irq_req_o), 0);
    pulse_ack();
    tick(); glob_en = 1; tick(); settle();
    chk("R6 masked ack ignored", int'(irq_req_o), 1);
    chk("R6 masked ack vec", int'(irq_vec_o), 2);

    // new edge together with the acknowledge of the same source
    tick(); irq_in[2] = 0; tick(); irq_in[2] = 1; ack_i = 1; tick(); ack_i = 0;
    pulse_reti(); settle();
    chk("R11 flag survives", int'(irq_req_o), 1);
    chk("R11 vec", int'(irq_vec_o), 2);
    pulse_ack(); pulse_reti(); settle();
    chk("R2 held line no repend", int'(irq_req_o), 0);

    // wake
    tick(); sleep_i = 1; grp_lvl[9:8] = 2'd3; irq_in[13] = 1; tick(); settle();
    chk("R10 unselected no wake", int'(wake_o), 0);
    tick(); wake_sel[13] = 1; tick(); settle();
    chk("R10 selected wake", int'(wake_o), 1);
    tick(); glob_en = 0; src_en[13] = 0; tick(); settle();
    chk("R10 wake ignores enables", int'(wake_o), 1);
    tick(); sleep_i = 0; glob_en = 1; src_en[13] = 1; tick(); settle();
    chk("R10 awake no wake", int'(wake_o), 0);
    chk("R4 group4 level", int'(irq_lvl_o), 3);
    pulse_ack(); pulse_reti();

    // randomised traffic against the reference
    for (int n = 0; n < 4000; n++) begin
      tick();
      for (int s = 0; s < NS; s++) if ($urandom_range(7) == 0) irq_in[s] = ~irq_in[s];
      ack_i   = ($urandom_range(3) == 0);
      reti_i  = ($urandom_range(5) == 0);
      glob_en = ($urandom_range(15) != 0);
      sleep_i = ($urandom_range(1) == 1);
      if ($urandom_range(31) == 0) grp_lvl = 12'($urandom);
      if ($urandom_range(15) == 0) wake_sel = 18'($urandom);
      src_en = '1;
      if ($urandom_range(3) == 0) src_en[$urandom_range(17)] = 1'b0;
    end
    tick(); ack_i = 0; reti_i = 0;
    repeat (3) tick();
    finish_run();
  end

endmodule